// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a single 32-bit memory-mapped control/status word that remembers which reset sources have fired since software last cleared the record. Six sticky cause flags sit in the upper byte. They belong to the power-on reset domain, so they survive a system reset and can be read after the chip restarts. The same word also carries an enable bit for a low-speed internal oscillator and a ready bit for that oscillator. The ready bit is synchronized to the bus clock and reads 0 whenever the oscillator is disabled.

Each reset source delivers a one-cycle pulse that is synchronous to the bus clock. A simple bus port reaches the register at a fixed offset. The port supports byte enables and carries a stall indication. When an access arrives in the cycle right after an accepted one, the register stalls it for one cycle and drops it. The requester must hold the access and present it again in the following cycle.

Top module: `rst_cause_csr`

## Requirements
- R1: After a power-on reset the word reads 0x0C00_0000. Flag bits 27 and 26 read 1, and all other bits, including the enable, read 0.
- R2: A one-cycle pulse on `cause_pulse_i[k]` sets flag bit 26+k, and the flag reads 1 from the next cycle. The mapping is k=5 low-power management (bit 31), k=4 window watchdog (bit 30), k=3 independent watchdog (bit 29), k=2 software (bit 28), k=1 power-on/power-down (bit 27), k=0 external pin (bit 26).
- R3: Bus writes to bits 31..26 neither set nor clear the flags.
- R4: An accepted write with `be_i[3]`=1 and `wdata_i[24]`=1 clears all six flags. Bit 24 always reads 0.
- R5: If a cause pulse arrives in the same cycle as a clearing write, that flag ends up at 1. The other flags are cleared.
- R6: A system reset (`sys_rst_ni` low) returns the enable bit to 0 and leaves the six flags unchanged.
- R7: Bit 0 (oscillator enable) is read/write. It is written only by an accepted write with `be_i[0]`=1.
- R8: Bit 1 equals `osc_ready_i` delayed through two flip-flop stages, gated by the enable. It reads 0 while the enable is 0.
- R9: Bit 25 and bits 23..2 always read 0.
- R10: An access takes effect only when `addr_i` equals the offset 0x24. At any other address the access has no effect and reads 0.
- R11: An access presented in the cycle right after an accepted access sees `wait_o`=1 and has no effect. Presented again in the next cycle, it is accepted with `wait_o`=0.
- R12: `rdata_o` carries the register word during an accepted read cycle (same cycle, combinational). In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous |
| cause_pulse_i | input | 6 | One-cycle pulse per reset source |
| osc_ready_i | input | 1 | Asynchronous ready level from the oscillator |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the access |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for an accepted read, else 0 |
| wait_o | output | 1 | Access stalled and dropped this cycle |
| osc_en_o | output | 1 | Oscillator enable to the oscillator |

## Verification
Assertions check the following on every cycle: each cause pulse sets its flag, a clear without a pulse empties the flag, no flag rises without its pulse, two accesses are never accepted back to back, the reserved bits stay zero, and the ready bit stays gated by the enable. The bench scenarios cover what no single-cycle property can show. A system reset spares the flags while a power-on reset restores 0x0C00_0000. A stalled write leaves no trace once it is retried. Byte lanes and address mismatches control which fields change. Random mixes of pulses, clearing writes and reads track a bench model of the word.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_CAUSE = 6;
  localparam int unsigned CAUSE_LSB = 26;
  localparam int unsigned WIPE_BIT  = 24;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned RDY_BIT   = 1;
  localparam int unsigned SYNC_DEPTH = 2;

  // flag slots, index k lands on bit CAUSE_LSB+k
  typedef enum logic [2:0] {
    CS_PIN   = 3'd0,
    CS_POWER = 3'd1,
    CS_SOFT  = 3'd2,
    CS_IWD   = 3'd3,
    CS_WWD   = 3'd4,
    CS_LOWP  = 3'd5
  } cause_slot_e;

  localparam logic [NUM_CAUSE-1:0] CAUSE_RST = 6'b00_0011;
  localparam logic [DATA_W-1:0]    ZERO_MASK = 32'h03FF_FFFC;
endpackage

// File: rtl/rst_sync_cell.sv
module rst_sync_cell #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/level_sync_cell.sv
module level_sync_cell #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cause_flag_bank.sv
module cause_flag_bank
  import rst_cause_pkg::*;
#(
  parameter int unsigned N = NUM_CAUSE,
  parameter logic [N-1:0] RST_VAL = CAUSE_RST
) (
  input  logic         clk,
  input  logic         por_rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wipe_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_comb begin
      flag_en[k] = set_i[k] | wipe_i;
      flag_d[k]  = set_i[k] | (flag_q[k] & ~wipe_i);
    end

    always_ff @(posedge clk or negedge por_rst_ni) begin
      if (!por_rst_ni)     flag_q[k] <= RST_VAL[k];
      else if (flag_en[k]) flag_q[k] <= flag_d[k];
    end

    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!por_rst_ni)
      set_i[k] |=> flag_q[k]);
    p_set_beats_wipe_r5: assert property (@(posedge clk) disable iff (!por_rst_ni)
      (set_i[k] && wipe_i) |=> flag_q[k]);
    p_wipe_empties_r4: assert property (@(posedge clk) disable iff (!por_rst_ni)
      (wipe_i && !set_i[k]) |=> !flag_q[k]);
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!por_rst_ni)
      !set_i[k] |=> !$rose(flag_q[k]));
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h24
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              accept_o,
  output logic              wait_o
);
  logic hit;
  logic busy_q;
  logic busy_d;

  always_comb begin
    hit      = req_i && (addr_i == OFFSET);
    wait_o   = hit && busy_q;
    accept_o = hit && !busy_q;
    busy_d   = accept_o;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  p_no_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  p_stall_follows_accept_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    wait_o |-> $past(accept_o));
endmodule

// File: rtl/rst_cause_csr.sv
module rst_cause_csr
  import rst_cause_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h24
) (
  input  logic                 clk,
  input  logic                 por_ni,
  input  logic                 sys_rst_ni,
  input  logic [NUM_CAUSE-1:0] cause_pulse_i,
  input  logic                 osc_ready_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W/8-1:0]  be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 wait_o,
  output logic                 osc_en_o
);
  localparam int unsigned LANE_HI = CAUSE_LSB / 8;
  localparam int unsigned LANE_EN = EN_BIT / 8;

  logic por_rst_n;
  logic sys_rst_n;
  logic sys_src_n;
  logic accept;
  logic wipe;
  logic en_q;
  logic en_d;
  logic en_we;
  logic rdy_sync;
  logic rdy_bit;
  logic [NUM_CAUSE-1:0] flags;
  logic [DATA_W-1:0] word;
  logic unused_bits;

  assign sys_src_n = sys_rst_ni & por_ni;

  rst_sync_cell #(.STAGES(SYNC_DEPTH)) u_por_sync (
    .clk(clk), .arst_ni(por_ni), .rst_no(por_rst_n));

  rst_sync_cell #(.STAGES(SYNC_DEPTH)) u_sys_sync (
    .clk(clk), .arst_ni(sys_src_n), .rst_no(sys_rst_n));

  csr_access_gate #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_gate (
    .clk(clk), .rst_ni(sys_rst_n), .req_i(req_i), .addr_i(addr_i),
    .accept_o(accept), .wait_o(wait_o));

  always_comb begin
    wipe  = accept && we_i && be_i[LANE_HI] && wdata_i[WIPE_BIT];
    en_we = accept && we_i && be_i[LANE_EN];
    en_d  = wdata_i[EN_BIT];
  end

  cause_flag_bank #(.N(NUM_CAUSE), .RST_VAL(CAUSE_RST)) u_flags (
    .clk(clk), .por_rst_ni(por_rst_n), .set_i(cause_pulse_i),
    .wipe_i(wipe), .flags_o(flags));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  en_q <= 1'b0;
    else if (en_we)  en_q <= en_d;
  end

  level_sync_cell #(.STAGES(SYNC_DEPTH)) u_rdy_sync (
    .clk(clk), .rst_ni(sys_rst_n), .async_i(osc_ready_i), .sync_o(rdy_sync));

  always_comb begin
    rdy_bit = rdy_sync & en_q;
    word = '0;
    word[CAUSE_LSB +: NUM_CAUSE] = flags;
    word[RDY_BIT] = rdy_bit;
    word[EN_BIT]  = en_q;
    rdata_o = (accept && !we_i) ? word : '0;
  end

  assign osc_en_o = en_q;
  assign unused_bits = ^{be_i, wdata_i};

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rdata_o & ZERO_MASK) == '0);
  p_ready_gated_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !osc_en_o |-> !rdata_o[RDY_BIT]);
  p_quiet_on_stall_r12: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wait_o |-> (rdata_o == '0));
endmodule

// File: tb/tb_rst_cause_csr.sv
module tb_rst_cause_csr;
  logic        clk = 1'b0;
  logic        por_ni, sys_rst_ni;
  logic [5:0]  cause_pulse_i;
  logic        osc_ready_i;
  logic        req_i, we_i;
  logic [7:0]  addr_i;
  logic [3:0]  be_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        wait_o, osc_en_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [5:0] m_flags;
  logic       m_en;
  logic       m_osc;

  always #10 clk = ~clk;

  rst_cause_csr dut (
    .clk(clk), .por_ni(por_ni), .sys_rst_ni(sys_rst_ni),
    .cause_pulse_i(cause_pulse_i), .osc_ready_i(osc_ready_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wait_o(wait_o), .osc_en_o(osc_en_o));

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[31:26] = m_flags;
    w[1] = m_en & m_osc;
    w[0] = m_en;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_i = 0; we_i = 0; be_i = 0; wdata_i = 0; cause_pulse_i = 0;
  endtask

  // drive one cycle, sample combinational outputs
  task automatic drive(input logic rq, input logic wr, input logic [7:0] ad,
                       input logic [3:0] be, input logic [31:0] wd, input logic [5:0] src,
                       output logic [31:0] rd, output logic wt);
    @(negedge clk);
    req_i = rq; we_i = wr; addr_i = ad; be_i = be; wdata_i = wd; cause_pulse_i = src;
    #2; rd = rdata_o; wt = wait_o;
  endtask

  task automatic wr_model(input logic [3:0] be, input logic [31:0] wd, input logic [5:0] src);
    if (be[0]) m_en = wd[0];
    if (be[3] && wd[24]) m_flags = 6'd0;
    m_flags = m_flags | src;
  endtask

  task automatic read_chk(input string req);
    logic [31:0] rd; logic wt;
    drive(1, 0, 8'h24, 4'hF, 0, 0, rd, wt);
    check(req, rd, exp_word());
    check(req, {31'd0, wt}, 32'd0);
    idle();
  endtask

  task automatic write(input logic [3:0] be, input logic [31:0] wd, input logic [5:0] src);
    logic [31:0] rd; logic wt;
    drive(1, 1, 8'h24, be, wd, src, rd, wt);
    wr_model(be, wd, src);
    idle();
  endtask

  task automatic power_on();
    por_ni = 0; sys_rst_ni = 0;
    repeat (3) @(negedge clk);
    por_ni = 1; sys_rst_ni = 1;
    repeat (3) @(negedge clk);
    m_flags = 6'b000011; m_en = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic wt;
    void'($urandom(32'd4242));
    req_i = 0; we_i = 0; addr_i = 8'h24; be_i = 0; wdata_i = 0;
    cause_pulse_i = 0; osc_ready_i = 0; m_osc = 0;
    power_on();

    // R1 power-on value
    read_chk("R1");
    check("R1", exp_word(), 32'h0C00_0000);

    // R7 enable with lane 0, R8 ready stays 0 while osc low
    write(4'h1, 32'h1, 0);
    read_chk("R7");
    write(4'hE, 32'h0, 0);      // lane 0 off: no change
    read_chk("R7");
    osc_ready_i = 1;
    repeat (3) @(negedge clk);
    m_osc = 1;
    read_chk("R8");
    write(4'h1, 32'h0, 0);
    read_chk("R8");             // gated to 0
    write(4'h1, 32'h1, 0);

    // R2 each source individually
    write(4'h8, 32'h0100_0000, 0);
    read_chk("R4");
    for (int k = 0; k < 6; k++) begin
      drive(0, 0, 8'h24, 0, 0, 6'(1 << k), rd, wt);
      m_flags |= 6'(1 << k);
      idle();
      read_chk("R2");
    end

    // R3 writes to flag bits without wipe: no effect, also zero writes
    write(4'hF, 32'h0000_0001, 0);
    read_chk("R3");
    write(4'h8, 32'hFC00_0000, 0);
    write(4'h7, 32'h0100_0001, 0);  // bit 24 set but lane 3 off
    read_chk("R3");

    // R4 clear, bit 24 reads 0; R5 set wins
    write(4'h8, 32'h0100_0000, 6'b001000);
    read_chk("R5");
    check("R5", {26'd0, m_flags}, 32'h8);

    // R10 wrong address: no effect, reads 0
    drive(1, 1, 8'h20, 4'hF, 32'h0100_0000, 0, rd, wt);
    idle();
    drive(1, 0, 8'h28, 4'hF, 0, 0, rd, wt);
    check("R10", rd, 32'd0);
    idle();
    read_chk("R10");

    // R11 back-to-back: second stalled and dropped, retried accepted
    drive(1, 1, 8'h24, 4'h1, 32'h0, 0, rd, wt);
    wr_model(4'h1, 32'h0, 0);
    check("R11", {31'd0, wt}, 32'd0);
    drive(1, 1, 8'h24, 4'h1, 32'h1, 0, rd, wt);
    check("R11", {31'd0, wt}, 32'd1);
    idle();
    read_chk("R11");            // enable still 0
    drive(1, 0, 8'h24, 4'hF, 0, 0, rd, wt);
    drive(1, 0, 8'h24, 4'hF, 0, 0, rd, wt);
    check("R12", rd, 32'd0);    // stalled read returns 0
    check("R11", {31'd0, wt}, 32'd1);
    drive(1, 0, 8'h24, 4'hF, 0, 0, rd, wt);
    check("R11", rd, exp_word());
    idle();
    check("R12", rdata_o, 32'd0);

    // R6 system reset keeps flags, clears enable
    write(4'h1, 32'h1, 6'b110000);
    sys_rst_ni = 0;
    repeat (2) @(negedge clk);
    sys_rst_ni = 1;
    repeat (4) @(negedge clk);
    m_en = 0;
    read_chk("R6");

    // random mix, R9 covered by compare of whole word
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 3);
      logic [5:0] src = 6'($urandom_range(0, 63)) & {6{($urandom_range(0, 3) == 0)}};
      logic [3:0] be = 4'($urandom_range(0, 15));
      logic [31:0] wd = $urandom();
      if (op == 0) begin
        drive(0, 0, 8'h24, 0, 0, 6'(1 << $urandom_range(0, 5)), rd, wt);
        m_flags |= cause_pulse_i;
        idle();
      end else if (op == 1) write(be, wd, src);
      else read_chk("R9");
    end
    read_chk("R9");

    // R1 power-on again restores the reset word
    power_on();
    read_chk("R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule